// File: doc/BRIEF.md
# Button-Freeze Memory Overlay Controller

This block sits on an 8-bit CPU bus with separate memory and I/O strobes. A front-panel freeze button makes it pull the CPU's active-low non-maskable interrupt line. It then watches the bus for the interrupt handler's first opcode fetch. When that fetch appears, it switches an 8K ROM and an 8K RAM over the bottom 16K of host memory, and it releases the interrupt line in the same step. The overlay code can then run from the ROM while the frozen program's state is kept in the RAM.

Software controls the overlay through one decoded I/O port. Address bit 7 of that access decides whether the overlay is switched in or out. A write that switches the overlay out also puts the block into a hidden state. Once hidden, the block ignores the button and the control port until reset. The block also watches writes to the host's memory-paging port and keeps a copy of data bit 3, the selected video page, so that the overlay software can learn it later.

Every bus input is registered once on the system clock. Each state change follows the start of a bus access, so an access held for many clocks acts only once. The chip selects are derived from the registered bus, so they lag the bus pins by one clock. The block has no streaming data path, so all of its pins are plain level signals.

Top module: `nmi_overlay_ctrl`

## Requirements
- R1: After reset, nmi_n=1, paged=0, stealth=0 and vid_page=0. With the bus idle, all chip selects are high and host_off=0.
- R2: A rising edge of button while the block is not hidden and no interrupt is pending drives nmi_n low. Holding the button down, or pressing it again while the interrupt is pending, does not produce a second assertion.
- R3: An opcode fetch (m1_n, mreq_n and rd_n all low) at address 0x0066 or 0x0067 while nmi_n is low sets paged and returns nmi_n high. A15..A1 are compared and A0 is ignored. A fetch at any other address, or a fetch while no interrupt is pending, changes neither nmi_n nor paged.
- R4: While paged, a memory read in 0x0000–0x1FFF drives rom_cs_n low. A memory write in that window leaves rom_cs_n high.
- R5: While paged, a memory access in 0x2000–0x3FFF drives ram_cs_n low. ram_we_n goes low only when wr_n is also low.
- R6: host_off is high exactly while paged and a memory access in 0x0000–0x3FFF is on the bus. It is low for addresses at 0x4000 and above.
- R7: An I/O access (iorq_n low with rd_n or wr_n low) whose low address byte has A5=1, A4=1 and A2=1 is a control access. With A7=1 it sets paged. With A7=0 it clears paged. An I/O access with any of A5, A4 or A2 low has no effect on paged.
- R8: A control write with A7=0 also sets stealth. Stealth stays set until reset. A control read with A7=0 only clears paged.
- R9: While stealth is set, button presses leave nmi_n high and control accesses leave paged unchanged.
- R10: An I/O write with A15=0 and A1=0 loads data bit 3 into vid_page, whether or not the block is hidden. I/O reads, and writes with A15=1, leave vid_page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| button | input | 1 | Freeze button, active high, already debounced |
| addr | input | 16 | CPU address bus |
| data_in | input | 8 | CPU data bus as seen on write cycles |
| m1_n | input | 1 | Opcode-fetch cycle strobe, active low |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| nmi_n | output | 1 | Non-maskable interrupt request to the CPU, active low |
| paged | output | 1 | Overlay is mapped over host low memory |
| stealth | output | 1 | Block is hidden from the button and the control port |
| vid_page | output | 1 | Copy of the last video-page bit written to the paging port |
| rom_cs_n | output | 1 | Overlay ROM select, active low |
| ram_cs_n | output | 1 | Overlay RAM select, active low |
| ram_we_n | output | 1 | Overlay RAM write enable, active low |
| host_off | output | 1 | Disables host memory while the overlay answers |

## Verification
Some rules hold on every cycle, and the assertions check those. The ROM and RAM selects never drive together. The interrupt line only falls while the block is not hidden, and it only releases together with paging in. The hidden state is sticky, and it comes up only as the overlay leaves. Other properties depend on decoding a particular bus pattern, and only the bench scenarios show those. These are the exact vector addresses, the control-port address mask and the effect of A7, the chip-select windows at their edges, the snooped data bit, and the fact that a held button or a press in the hidden state has no effect.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  // registered bus view, all strobes active high
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              fetch;
    logic              mreq;
    logic              iorq;
    logic              rd;
    logic              wr;
  } ovl_bus_t;
endpackage

// File: rtl/ovl_bus_sync.sv
module ovl_bus_sync
  import ovl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              button,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              m1_n,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output ovl_bus_t          bus_q,
  output logic              fetch_stb,
  output logic              io_stb,
  output logic              iowr_stb,
  output logic              btn_stb
);
  logic fetch_d, io_d, iowr_d, btn_q, btn_d;
  logic fetch_now, io_now, iowr_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q  <= '0;
      btn_q  <= 1'b0;
      btn_d  <= 1'b0;
      fetch_d <= 1'b0;
      io_d    <= 1'b0;
      iowr_d  <= 1'b0;
    end else begin
      bus_q.addr  <= addr;
      bus_q.data  <= data_in;
      bus_q.fetch <= ~m1_n;
      bus_q.mreq  <= ~mreq_n;
      bus_q.iorq  <= ~iorq_n;
      bus_q.rd    <= ~rd_n;
      bus_q.wr    <= ~wr_n;
      btn_q   <= button;
      btn_d   <= btn_q;
      fetch_d <= fetch_now;
      io_d    <= io_now;
      iowr_d  <= iowr_now;
    end
  end

  assign fetch_now = bus_q.fetch & bus_q.mreq & bus_q.rd;
  assign io_now    = bus_q.iorq & (bus_q.rd | bus_q.wr);
  assign iowr_now  = bus_q.iorq & bus_q.wr;

  // one pulse at the start of each access
  assign fetch_stb = fetch_now & ~fetch_d;
  assign io_stb    = io_now & ~io_d;
  assign iowr_stb  = iowr_now & ~iowr_d;
  assign btn_stb   = btn_q & ~btn_d;
endmodule

// File: rtl/ovl_decode.sv
module ovl_decode
  import ovl_pkg::*;
#(
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'h0066,
  parameter int                WIN_BITS = 13
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              vec_hit,
  output logic              ctl_hit,
  output logic              ctl_in,
  output logic              snoop_hit,
  output logic              rom_win,
  output logic              ram_win
);
  localparam int HI_W = ADDR_W - WIN_BITS;

  logic [HI_W-1:0] blk;
  assign blk = addr[ADDR_W-1:WIN_BITS];

  // A0 is a don't-care so both vector bytes match
  assign vec_hit   = (addr[ADDR_W-1:1] == VEC_ADDR[ADDR_W-1:1]);
  assign ctl_hit   = addr[5] & addr[4] & addr[2];
  assign ctl_in    = addr[7];
  assign snoop_hit = ~addr[ADDR_W-1] & ~addr[1];
  assign rom_win   = (blk == HI_W'(0));
  assign ram_win   = (blk == HI_W'(1));
endmodule

// File: rtl/ovl_state.sv
module ovl_state
  import ovl_pkg::*;
#(
  parameter int VID_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_stb,
  input  logic              fetch_stb,
  input  logic              io_stb,
  input  logic              iowr_stb,
  input  logic              vec_hit,
  input  logic              ctl_hit,
  input  logic              ctl_in,
  input  logic              snoop_hit,
  input  logic              is_write,
  input  logic [DATA_W-1:0] data,
  output logic              nmi_pend,
  output logic              paged,
  output logic              stealth,
  output logic              vid_page
);
  logic arm, ctl_act;

  assign arm     = fetch_stb & vec_hit & nmi_pend;
  assign ctl_act = io_stb & ctl_hit & ~stealth;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_pend <= 1'b0;
      paged    <= 1'b0;
      stealth  <= 1'b0;
      vid_page <= 1'b0;
    end else begin
      if (arm)
        nmi_pend <= 1'b0;
      else if (btn_stb && !stealth)
        nmi_pend <= 1'b1;

      if (arm)
        paged <= 1'b1;
      else if (ctl_act)
        paged <= ctl_in;

      if (ctl_act && !ctl_in && is_write)
        stealth <= 1'b1;

      if (iowr_stb && snoop_hit)
        vid_page <= data[VID_BIT];
    end
  end
endmodule

// File: rtl/nmi_overlay_ctrl.sv
module nmi_overlay_ctrl
  import ovl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        button,
  input  logic [15:0] addr,
  input  logic [7:0]  data_in,
  input  logic        m1_n,
  input  logic        mreq_n,
  input  logic        iorq_n,
  input  logic        rd_n,
  input  logic        wr_n,
  output logic        nmi_n,
  output logic        paged,
  output logic        stealth,
  output logic        vid_page,
  output logic        rom_cs_n,
  output logic        ram_cs_n,
  output logic        ram_we_n,
  output logic        host_off
);
  ovl_bus_t bus_q;
  logic fetch_stb, io_stb, iowr_stb, btn_stb;
  logic vec_hit, ctl_hit, ctl_in, snoop_hit, rom_win, ram_win;
  logic nmi_pend;

  ovl_bus_sync u_sync (
    .clk(clk), .rst_n(rst_n), .button(button), .addr(addr), .data_in(data_in),
    .m1_n(m1_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_q(bus_q), .fetch_stb(fetch_stb), .io_stb(io_stb),
    .iowr_stb(iowr_stb), .btn_stb(btn_stb)
  );

  ovl_decode u_dec (
    .addr(bus_q.addr), .vec_hit(vec_hit), .ctl_hit(ctl_hit), .ctl_in(ctl_in),
    .snoop_hit(snoop_hit), .rom_win(rom_win), .ram_win(ram_win)
  );

  ovl_state u_state (
    .clk(clk), .rst_n(rst_n), .btn_stb(btn_stb), .fetch_stb(fetch_stb),
    .io_stb(io_stb), .iowr_stb(iowr_stb), .vec_hit(vec_hit), .ctl_hit(ctl_hit),
    .ctl_in(ctl_in), .snoop_hit(snoop_hit), .is_write(bus_q.wr),
    .data(bus_q.data), .nmi_pend(nmi_pend), .paged(paged), .stealth(stealth),
    .vid_page(vid_page)
  );

  logic mem_acc;
  assign mem_acc  = bus_q.mreq & (bus_q.rd | bus_q.wr);
  assign nmi_n    = ~nmi_pend;
  assign rom_cs_n = ~(paged & mem_acc & rom_win & bus_q.rd);
  assign ram_cs_n = ~(paged & mem_acc & ram_win);
  assign ram_we_n = ~(paged & mem_acc & ram_win & bus_q.wr);
  assign host_off = paged & mem_acc & (rom_win | ram_win);
endmodule

// File: rtl/nmi_overlay_ctrl_chk.sv
module nmi_overlay_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic nmi_n,
  input logic paged,
  input logic stealth,
  input logic rom_cs_n,
  input logic ram_cs_n,
  input logic ram_we_n
);
  // R2
  nmi_only_when_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_n) |-> !stealth);
  // R3
  nmi_release_pages_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_n) |-> paged);
  // R8
  stealth_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stealth |=> stealth);
  // R8
  stealth_rises_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stealth) |-> !paged);
  // R4
  single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_cs_n && !ram_cs_n));
  // R5
  we_within_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> !ram_cs_n);
endmodule

bind nmi_overlay_ctrl nmi_overlay_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .paged(paged), .stealth(stealth),
  .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n)
);

// File: tb/nmi_overlay_ctrl_bench.sv
module nmi_overlay_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic button = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] data_in = '0;
  logic m1_n = 1'b1, mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic nmi_n, paged, stealth, vid_page, rom_cs_n, ram_cs_n, ram_we_n, host_off;

  always #4 clk = ~clk;

  nmi_overlay_ctrl u_nmi_overlay_ctrl (
    .clk(clk), .rst_n(rst_n), .button(button), .addr(addr), .data_in(data_in),
    .m1_n(m1_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .nmi_n(nmi_n), .paged(paged), .stealth(stealth), .vid_page(vid_page),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
    .host_off(host_off)
  );

  // observed vector: {nmi_n, paged, stealth, vid_page, rom_cs_n, ram_cs_n, ram_we_n, host_off}
  logic [7:0] obs;
  assign obs = {nmi_n, paged, stealth, vid_page, rom_cs_n, ram_cs_n, ram_we_n, host_off};

  typedef struct { string req; logic [7:0] exp; } item_t;
  item_t sb[$];
  event chk_ev;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  // monitor: pops each expected item and compares with the outputs
  initial forever begin
    @(chk_ev);
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_vec++;
      if (obs !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b", it.req, obs, it.exp);
      end
    end
  end

  task automatic expect_st(string r, logic [7:0] e);
    sb.push_back('{r, e});
    -> chk_ev;
    #1;
  endtask

  function automatic logic [7:0] idle(logic n, logic p, logic s, logic v);
    return {n, p, s, v, 4'b1110};
  endfunction

  task automatic idle_bus();
    addr = '0; data_in = '0;
    m1_n = 1'b1; mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  // full access: drive, hold, release, settle; ends at a negedge
  task automatic cyc(logic [15:0] a, logic [7:0] d, logic f, logic m, logic io, logic r, logic w);
    @(negedge clk);
    addr = a; data_in = d;
    m1_n = ~f; mreq_n = ~m; iorq_n = ~io; rd_n = ~r; wr_n = ~w;
    repeat (3) @(posedge clk);
    @(negedge clk);
    idle_bus();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  // memory access checked while still on the bus
  task automatic mem_probe(string r, logic [15:0] a, logic w, logic [7:0] e);
    @(negedge clk);
    addr = a; mreq_n = 1'b0; rd_n = w; wr_n = ~w;
    repeat (2) @(posedge clk);
    @(negedge clk);
    expect_st(r, e);
    idle_bus();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic press(logic hold_down);
    @(negedge clk); button = 1'b1;
    repeat (3) @(posedge clk);
    if (!hold_down) begin @(negedge clk); button = 1'b0; end
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    expect_st("R1 reset state", idle(1, 0, 0, 0));

    // R10 snoop of the paging port (0x7FF9 avoids the control mask)
    cyc(16'h7FF9, 8'h08, 0, 0, 1, 0, 1);
    expect_st("R10 D3 latched", idle(1, 0, 0, 1));
    cyc(16'hFFF9, 8'h00, 0, 0, 1, 0, 1);
    expect_st("R10 A15=1 ignored", idle(1, 0, 0, 1));
    cyc(16'h7FF9, 8'h00, 0, 0, 1, 1, 0);
    expect_st("R10 read ignored", idle(1, 0, 0, 1));
    cyc(16'h7FF9, 8'hF7, 0, 0, 1, 0, 1);
    expect_st("R10 D3 cleared", idle(1, 0, 0, 0));

    // R3 fetch at vector with no pending interrupt
    cyc(16'h0066, 8'h00, 1, 1, 0, 1, 0);
    expect_st("R3 fetch without nmi", idle(1, 0, 0, 0));

    // R2 button press, held down
    press(1);
    expect_st("R2 nmi asserted", idle(0, 0, 0, 0));
    cyc(16'h0068, 8'h00, 1, 1, 0, 1, 0);
    expect_st("R3 off-vector fetch", idle(0, 0, 0, 0));
    cyc(16'h0067, 8'h00, 1, 1, 0, 1, 0);
    expect_st("R3 vector 0x0067 arms", idle(1, 1, 0, 0));
    repeat (4) @(posedge clk); @(negedge clk);
    expect_st("R2 held button no repeat", idle(1, 1, 0, 0));
    button = 1'b0;

    // R4 R5 R6 chip selects while paged
    mem_probe("R4 rom read", 16'h0100, 0, {4'b1100, 4'b0111});
    mem_probe("R4 rom write ignored", 16'h1FFF, 1, {4'b1100, 4'b1111});
    mem_probe("R5 ram read", 16'h2000, 0, {4'b1100, 4'b1011});
    mem_probe("R5 ram write", 16'h3FFF, 1, {4'b1100, 4'b1001});
    mem_probe("R6 above window", 16'h4000, 0, {4'b1100, 4'b1110});

    // R7 control port
    cyc(16'h003F, 8'h00, 0, 0, 1, 1, 0);
    expect_st("R7 read A7=0 pages out", idle(1, 0, 0, 0));
    mem_probe("R6 host kept unpaged", 16'h0100, 0, {4'b1000, 4'b1110});
    cyc(16'h00AF, 8'h00, 0, 0, 1, 1, 0);
    expect_st("R7 A4=0 ignored", idle(1, 0, 0, 0));
    cyc(16'h00BF, 8'h00, 0, 0, 1, 1, 0);
    expect_st("R7 A7=1 pages in", idle(1, 1, 0, 0));

    // second freeze with vector 0x0066
    press(0);
    expect_st("R2 second press", idle(0, 1, 0, 0));
    press(0);
    expect_st("R2 press while pending", idle(0, 1, 0, 0));
    cyc(16'h0066, 8'h00, 1, 1, 0, 1, 0);
    expect_st("R3 vector 0x0066 releases", idle(1, 1, 0, 0));

    // R8 write A7=0 hides
    cyc(16'h0034, 8'h00, 0, 0, 1, 0, 1);
    expect_st("R8 write sets stealth", idle(1, 0, 1, 0));

    // R9 hidden: button and port ignored
    press(0);
    expect_st("R9 button ignored", idle(1, 0, 1, 0));
    cyc(16'h00BF, 8'h00, 0, 0, 1, 1, 0);
    expect_st("R9 port ignored", idle(1, 0, 1, 0));
    cyc(16'h7FF9, 8'h08, 0, 0, 1, 0, 1);
    expect_st("R10 snoop while hidden", idle(1, 0, 1, 1));

    // R1 reset clears hidden state
    rst_n = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    expect_st("R1 reset clears stealth", idle(1, 0, 0, 0));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule